// File: doc/BRIEF.md
# Conditional Delayed-Branch PC Sequencer

This block owns the fetch address of a processor whose instructions are 16 bits wide and whose addresses are 32 bits wide. It carries out one control-flow operation: a branch taken when the condition flag is clear, with a single delay slot. Each advancing cycle, decode reports whether the instruction at the current fetch address is such a branch. Decode also supplies the 8-bit displacement and the present condition flag.

When the branch is taken, the block works out the destination at once and holds it. It then lets the next sequential instruction run as the delay slot. Only after that does it move the fetch address to the stored destination. A branch that is not taken is handled like any other instruction: the address moves on by one instruction. A branch reported while the delay slot is executing raises a fault indication to the exception logic and is otherwise ignored. When the advance input is low, the whole sequencer is frozen.

Top module: `pc_branch_seq`

## Requirements
- R1: While synchronous reset is high at a clock edge, `fetch_pc` is loaded with `RESET_VEC` (default 0x0000_1000) and `in_slot` is cleared, so no branch is pending.
- R2: A branch strobe with `t_flag` = 1 is not taken: on the next advancing edge `fetch_pc` increases by 2 and `in_slot` stays 0.
- R3: An advancing cycle with no branch strobe increases `fetch_pc` by 2.
- R4: A branch strobe with `t_flag` = 0 and `in_slot` = 0 is taken: on the next advancing edge `fetch_pc` becomes the branch address + 2 (the delay slot) and `in_slot` becomes 1.
- R5: The destination is the branch address + 4 + (displacement sign-extended from bit 7, shifted left by 1). The extremes 0x7F (+254) and 0x80 (-256) are included.
- R6: The destination is fixed when the branch is accepted. Changes to `br_disp` and `t_flag` during the delay slot do not alter the address that is jumped to.
- R7: `in_slot` is high for exactly one advancing instruction. The advancing edge that leaves the slot loads the held destination into `fetch_pc` and clears `in_slot`.
- R8: A branch strobe in an advancing cycle while `in_slot` is 1 drives `slot_fault` high in that same cycle. No new branch starts, and the redirect to the earlier destination still happens. `slot_fault` is 0 in every other cycle.
- R9: While `advance` is 0, `fetch_pc`, `in_slot` and the held destination keep their values, including during a delay slot.
- R10: A branch at the redirect destination, strobed in the cycle right after the redirect, is taken normally (back-to-back branches).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Pipeline advance; low freezes all state |
| br_strobe | input | 1 | Instruction at `fetch_pc` is a branch-if-clear |
| br_disp | input | 8 | Signed displacement in instructions |
| t_flag | input | 1 | Condition flag; branch taken when 0 |
| fetch_pc | output | 32 | Address of the current instruction |
| in_slot | output | 1 | Current instruction is a delay slot |
| slot_fault | output | 1 | Branch strobed inside a delay slot |

## Verification
The hardest case to reach from the ports is a stall that falls inside the delay slot. The stimulus must also change the displacement and the flag while the slot is pending and stalled, because the stored destination has to survive both the freeze and the input changes. The bench takes a branch, then holds `advance` low for several cycles with different `br_disp` and `t_flag` values. It then releases the slot with a strobe that should fault, and checks that the redirect still lands on the first destination. A second branch is strobed immediately at that destination.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD     = 2'd0,
        ACT_STEP     = 2'd1,
        ACT_TAKE     = 2'd2,
        ACT_REDIRECT = 2'd3
    } pcb_act_e;
endpackage

// File: rtl/pcb_target.sv
module pcb_target #(
    parameter int ADDR_W   = 32,
    parameter int DISP_W   = 8,
    parameter int PIPE_OFS = 4,
    parameter int SHIFT    = 1
) (
    input  logic [ADDR_W-1:0] base_pc,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] dest
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] disp_bytes;

    always_comb begin
        disp_ext   = {{EXT_W{disp[DISP_W-1]}}, disp};
        disp_bytes = disp_ext << SHIFT;
        dest       = base_pc + ADDR_W'(PIPE_OFS) + disp_bytes;
    end
endmodule

// File: rtl/pcb_decide.sv
module pcb_decide
    import pcb_pkg::*;
(
    input  logic     advance,
    input  logic     br_strobe,
    input  logic     t_flag,
    input  logic     slot_pend,
    output pcb_act_e act,
    output logic     fault
);
    always_comb begin
        act   = ACT_HOLD;
        fault = 1'b0;
        if (advance) begin
            if (slot_pend) begin
                act   = ACT_REDIRECT;
                fault = br_strobe;
            end else if (br_strobe && !t_flag) begin
                act = ACT_TAKE;
            end else begin
                act = ACT_STEP;
            end
        end
    end
endmodule

// File: rtl/pc_branch_seq.sv
module pc_branch_seq
    import pcb_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                DISP_W    = 8,
    parameter int                INSTR_B   = 2,
    parameter int                PIPE_OFS  = 4,
    parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              br_strobe,
    input  logic [DISP_W-1:0] br_disp,
    input  logic              t_flag,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic              in_slot,
    output logic              slot_fault
);
    localparam int                SHIFT = $clog2(INSTR_B);
    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(INSTR_B);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] tgt;
        logic              slot;
    } seq_state_t;

    seq_state_t st_d, st_q;
    pcb_act_e   act;
    logic       fault;
    logic [ADDR_W-1:0] dest;
    logic [ADDR_W-1:0] held_tgt;

    pcb_target #(
        .ADDR_W  (ADDR_W),
        .DISP_W  (DISP_W),
        .PIPE_OFS(PIPE_OFS),
        .SHIFT   (SHIFT)
    ) u_target (
        .base_pc(st_q.pc),
        .disp   (br_disp),
        .dest   (dest)
    );

    pcb_decide u_decide (
        .advance  (advance),
        .br_strobe(br_strobe),
        .t_flag   (t_flag),
        .slot_pend(st_q.slot),
        .act      (act),
        .fault    (fault)
    );

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_STEP: begin
                st_d.pc = st_q.pc + STEP;
            end
            ACT_TAKE: begin
                st_d.pc   = st_q.pc + STEP;
                st_d.tgt  = dest;
                st_d.slot = 1'b1;
            end
            ACT_REDIRECT: begin
                st_d.pc   = st_q.tgt;
                st_d.slot = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pc   <= RESET_VEC;
            st_q.tgt  <= RESET_VEC;
            st_q.slot <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_pc   = st_q.pc;
    assign in_slot    = st_q.slot;
    assign slot_fault = fault;
    assign held_tgt   = st_q.tgt;
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0000_1000
) (
    input logic              clk,
    input logic              rst,
    input logic              advance,
    input logic              br_strobe,
    input logic              t_flag,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              in_slot,
    input logic              slot_fault,
    input logic [ADDR_W-1:0] tgt_q
);
    assert_reset_vector_R1: assert property (@(posedge clk)
        rst |=> (fetch_pc == RESET_VEC && !in_slot));

    assert_not_taken_step_R2: assert property (@(posedge clk) disable iff (rst)
        (advance && !in_slot && br_strobe && t_flag)
        |=> (fetch_pc == $past(fetch_pc) + 32'd2 && !in_slot));

    assert_plain_step_R3: assert property (@(posedge clk) disable iff (rst)
        (advance && !in_slot && !br_strobe)
        |=> (fetch_pc == $past(fetch_pc) + 32'd2));

    assert_enter_slot_R4: assert property (@(posedge clk) disable iff (rst)
        (advance && !in_slot && br_strobe && !t_flag)
        |=> (in_slot && fetch_pc == $past(fetch_pc) + 32'd2));

    assert_redirect_held_R6: assert property (@(posedge clk) disable iff (rst)
        (advance && in_slot) |=> (fetch_pc == $past(tgt_q)));

    assert_single_slot_R7: assert property (@(posedge clk) disable iff (rst)
        (advance && in_slot) |=> !in_slot);

    assert_fault_only_in_slot_R8: assert property (@(posedge clk) disable iff (rst)
        slot_fault |-> (in_slot && br_strobe && advance));

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !advance |=> ($stable(fetch_pc) && $stable(in_slot) && $stable(tgt_q)));
endmodule

bind pc_branch_seq pcb_checker #(
    .ADDR_W   (ADDR_W),
    .RESET_VEC(RESET_VEC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .advance   (advance),
    .br_strobe (br_strobe),
    .t_flag    (t_flag),
    .fetch_pc  (fetch_pc),
    .in_slot   (in_slot),
    .slot_fault(slot_fault),
    .tgt_q     (held_tgt)
);

// File: tb/tb_pc_branch_seq.sv
module tb_pc_branch_seq;
    localparam logic [31:0] RVEC = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        advance = 1'b0;
    logic        br_strobe = 1'b0;
    logic [7:0]  br_disp = 8'h00;
    logic        t_flag = 1'b1;
    logic [31:0] fetch_pc;
    logic        in_slot;
    logic        slot_fault;

    int tests = 0;
    int fails = 0;

    logic [31:0] exp_pc_q[$];
    bit          exp_slot_q[$];
    string       exp_tag_q[$];

    logic [31:0] m_pc;
    logic [31:0] m_tgt;
    bit          m_slot;

    always #10 clk = ~clk;

    pc_branch_seq #(.RESET_VEC(RVEC)) dut (
        .clk(clk), .rst(rst), .advance(advance), .br_strobe(br_strobe),
        .br_disp(br_disp), .t_flag(t_flag), .fetch_pc(fetch_pc),
        .in_slot(in_slot), .slot_fault(slot_fault)
    );

    // Monitor: pop one expected item after each edge that had one queued
    always @(posedge clk) begin
        #1;
        if (exp_pc_q.size() > 0) begin
            logic [31:0] epc;
            bit          esl;
            string       etag;
            epc  = exp_pc_q.pop_front();
            esl  = exp_slot_q.pop_front();
            etag = exp_tag_q.pop_front();
            tests++;
            if (fetch_pc !== epc || in_slot !== esl) begin
                fails++;
                $display("FAIL %s: pc=%h slot=%b expected pc=%h slot=%b",
                         etag, fetch_pc, in_slot, epc, esl);
            end
        end
    end

    // Driver: apply one cycle of stimulus, check fault now, queue next state
    task automatic step(input bit adv, input bit strb, input logic [7:0] d,
                        input bit t, input string tag);
        bit          fexp;
        logic [31:0] ext;
        @(negedge clk);
        advance = adv; br_strobe = strb; br_disp = d; t_flag = t;
        fexp = adv && strb && m_slot;
        #1;
        tests++;
        if (slot_fault !== fexp) begin
            fails++;
            $display("FAIL %s: slot_fault=%b expected %b", tag, slot_fault, fexp);
        end
        if (adv) begin
            if (m_slot) begin
                m_pc = m_tgt; m_slot = 0;
            end else if (strb && !t) begin
                ext   = {{24{d[7]}}, d};
                m_tgt = m_pc + 32'd4 + (ext << 1);
                m_pc  = m_pc + 32'd2; m_slot = 1;
            end else begin
                m_pc = m_pc + 32'd2;
            end
        end
        exp_pc_q.push_back(m_pc);
        exp_slot_q.push_back(m_slot);
        exp_tag_q.push_back(tag);
    endtask

    task automatic expect_pc(input logic [31:0] v, input string tag);
        tests++;
        if (m_pc !== v) begin
            fails++;
            $display("FAIL %s: model pc=%h expected %h", tag, m_pc, v);
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        m_pc = RVEC; m_tgt = RVEC; m_slot = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        tests++; // R1 reset state
        if (fetch_pc !== RVEC || in_slot !== 1'b0 || slot_fault !== 1'b0) begin
            fails++;
            $display("FAIL R1: pc=%h slot=%b fault=%b expected pc=%h slot=0 fault=0",
                     fetch_pc, in_slot, slot_fault, RVEC);
        end
        step(1, 0, 8'h00, 1, "R3");             // plain step
        step(1, 0, 8'h55, 0, "R3");
        step(1, 1, 8'h10, 1, "R2");             // not taken
        step(1, 1, 8'h10, 0, "R4");             // taken forward 0x10
        step(1, 0, 8'h80, 1, "R6");             // slot, inputs changed
        expect_pc(32'h0000_1006 + 32'd4 + 32'd32, "R5");
        step(1, 1, 8'h7F, 0, "R5");             // max positive
        step(1, 0, 8'h00, 0, "R7");
        step(1, 0, 8'h00, 1, "R7");             // slot flag cleared, plain step
        step(1, 1, 8'h80, 0, "R5");             // most negative
        step(1, 0, 8'h00, 1, "R7");
        step(1, 1, 8'hFE, 0, "R4");             // small negative
        step(0, 1, 8'h22, 0, "R9");             // stall in slot
        step(0, 0, 8'h81, 1, "R9");
        step(0, 1, 8'h7F, 1, "R9");
        step(1, 1, 8'h40, 0, "R8");             // strobe in slot: fault, redirect
        step(1, 1, 8'h03, 0, "R10");            // back-to-back branch
        step(1, 0, 8'h00, 1, "R7");
        step(1, 1, 8'h01, 0, "R10");
        step(1, 0, 8'h00, 1, "R7");
        step(0, 0, 8'h00, 1, "R9");             // stall outside slot
        step(1, 0, 8'h00, 1, "R3");
        @(negedge clk); advance = 1'b0; br_strobe = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule